// File: doc/BRIEF.md
# UART Interrupt Priority and Status Unit

This block sits beside a UART and collects the five events that can need host attention: a receive line error, received data ready, a receive time-out, an empty transmit holding register and a modem status change. Each event arrives as a one-cycle pulse. The block latches the pulse into a pending flag, but only if that source is enabled. It then presents the most urgent pending source as an encoded status byte on a simple read port.

The host reads the status byte and raises a read strobe. The block then drops only the flag it just reported, so the next read shows the next source in priority order. A single active-high interrupt request is raised while any enabled source is pending. A configuration write loads the per-source enables and a FIFO-mode indication. The FIFO-mode indication is echoed in the top two status bits.

Top module: `uart_irq_prio`

## Requirements
- R1: A synchronous active-high reset clears all pending flags, all enables and the FIFO-mode indication. After reset the status byte reads 0x01 and the interrupt request is low.
- R2: The event input bit positions are: [0] line error, [1] data ready, [2] time-out, [3] transmit empty, [4] modem change. When a source is reported, status[3:0] is 0110, 0100, 1100, 0010 and 0000 respectively.
- R3: Priority runs from highest to lowest as line error, then the shared data-ready/time-out level, then transmit empty, then modem change. Only the highest pending source is reported.
- R4: When data ready and time-out are both pending, data ready is reported first.
- R5: status[0] is 0 while any source is pending and 1 otherwise. The interrupt request output is always the inverse of status[0].
- R6: status[7:6] read 11 while FIFO mode is set and 00 otherwise. status[5:4] always read 00.
- R7: A read strobe clears, at the next clock edge, only the flag of the source shown in that cycle. Other pending flags remain set and are reported by later reads.
- R8: An event pulse in the same cycle as the read that clears its own flag sets that flag again, so the event is not lost.
- R9: An event pulse for a disabled source never sets its flag.
- R10: A configuration write that clears a source's enable also clears that source's pending flag at the same edge.
- R11: A pending flag holds after its pulse ends, until a read or a disable clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evtIn | input | 5 | One-cycle event pulses, one bit per source (positions in R2) |
| statusRd | input | 1 | Host read strobe for the status byte |
| cfgWr | input | 1 | Loads cfgEnables and cfgFifoOn at the next edge |
| cfgEnables | input | 5 | Per-source enable bits, same positions as evtIn |
| cfgFifoOn | input | 1 | FIFO-mode indication to echo in status[7:6] |
| statusData | output | 8 | Encoded status byte |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The status byte and the interrupt request are combinational views of registered state. An event pulse, a read or a configuration write therefore shows its effect exactly one clock edge after the cycle it is presented in. The bench drives each stimulus shortly after a rising edge. It lets one rising edge consume it and compares the outputs at the following falling edge, where both the design and the reference model have taken that single edge. The reference model applies its read-clear, its enable load and its event set in the same order as R7, R8 and R10. The model is compared on every falling edge, and the directed checks sample at the same point.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 5;
  localparam int CODE_W  = 4;
  localparam int STAT_W  = 8;

  // Source index doubles as priority rank (0 = most urgent).
  typedef enum int unsigned {
    SRC_LINE_ERR = 0,
    SRC_RX_READY = 1,
    SRC_RX_TMO   = 2,
    SRC_TX_EMPTY = 3,
    SRC_MODEM    = 4
  } srcIdx_e;

  localparam logic [CODE_W-1:0] SRC_CODE [NUM_SRC] = '{
    4'b0110,  // line error
    4'b0100,  // data ready
    4'b1100,  // time-out
    4'b0010,  // transmit empty
    4'b0000   // modem change
  };

  localparam logic [CODE_W-1:0] IDLE_CODE = 4'b0001;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [NUM_SRC-1:0] clrMask;
    logic               loadCfg;
  } ctrlStrobe_t;

endpackage

// File: rtl/uart_irq_pick.sv
module uart_irq_pick
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]      pend,
  output logic [N-1:0]      winner,
  output logic              anyPend,
  output logic [CODE_W-1:0] code
);

  // Lowest index wins; later indices are masked by everything above them.
  logic [N:0] seenAbove;

  assign seenAbove[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_rank
    assign winner[g]      = pend[g] & ~seenAbove[g];
    assign seenAbove[g+1] = seenAbove[g] | pend[g];
  end

  assign anyPend = seenAbove[N];

  always_comb begin
    code = IDLE_CODE;
    for (int i = 0; i < N; i++) begin
      if (winner[i]) code = SRC_CODE[i];
    end
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         statusRd,
  input  logic         cfgWr,
  input  logic [N-1:0] winner,
  output ctrlStrobe_t  strobe
);

  // The read retires exactly the source on display in this cycle.
  always_comb begin
    strobe.clrMask = statusRd ? winner : '0;
    strobe.loadCfg = cfgWr;
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [N-1:0]      evtIn,
  input  logic [N-1:0]      cfgEnables,
  input  logic              cfgFifoOn,
  output logic [N-1:0]      winner,
  output logic [STAT_W-1:0] statusData,
  output logic              irqOut
);

  logic [N-1:0]      enReg;
  logic [N-1:0]      enNext;
  logic [N-1:0]      pendReg;
  logic              fifoReg;
  logic              anyPend;
  logic [CODE_W-1:0] code;

  assign enNext = strobe.loadCfg ? cfgEnables : enReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg   <= '0;
      fifoReg <= 1'b0;
    end else if (strobe.loadCfg) begin
      enReg   <= cfgEnables;
      fifoReg <= cfgFifoOn;
    end
  end

  // Clear first, then set: a same-cycle event survives its own clear.
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) pendReg[g] <= 1'b0;
      else     pendReg[g] <= enNext[g] & ((pendReg[g] & ~strobe.clrMask[g]) | evtIn[g]);
    end
  end

  uart_irq_pick #(.N(N)) u_pick (
    .pend    (pendReg),
    .winner  (winner),
    .anyPend (anyPend),
    .code    (code)
  );

  assign statusData = {fifoReg, fifoReg, 2'b00, code};
  assign irqOut     = anyPend;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [4:0]   evtIn,
  input  logic         statusRd,
  input  logic         cfgWr,
  input  logic [4:0]   cfgEnables,
  input  logic         cfgFifoOn,
  output logic [7:0]   statusData,
  output logic         irqOut
);

  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] winner;

  uart_irq_ctrl #(.N(NUM_SRC)) u_ctrl (
    .statusRd (statusRd),
    .cfgWr    (cfgWr),
    .winner   (winner),
    .strobe   (strobe)
  );

  uart_irq_dp #(.N(NUM_SRC)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .evtIn      (evtIn),
    .cfgEnables (cfgEnables),
    .cfgFifoOn  (cfgFifoOn),
    .winner     (winner),
    .statusData (statusData),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] evtIn,
  input logic       statusRd,
  input logic       cfgWr,
  input logic [4:0] cfgEnables,
  input logic [7:0] statusData,
  input logic       irqOut
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (statusData == 8'h01 && !irqOut));  // R1

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    statusData[3:0] inside {4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000, 4'b0001});  // R2

  AST_IRQ_INVERSE: assert property (@(posedge clk) disable iff (rst)
    irqOut == !statusData[0]);  // R5

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    statusData[5:4] == 2'b00 && statusData[7] == statusData[6]);  // R6

  AST_READ_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (statusRd && !statusData[0] && evtIn == 5'b0 && !cfgWr)
      |=> statusData[3:0] != $past(statusData[3:0]));  // R7

  AST_DISABLE_ALL: assert property (@(posedge clk) disable iff (rst)
    (cfgWr && cfgEnables == 5'b0) |=> !irqOut);  // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!statusRd && !cfgWr && !statusData[0]) |=> !statusData[0]);  // R11

endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .evtIn      (evtIn),
  .statusRd   (statusRd),
  .cfgWr      (cfgWr),
  .cfgEnables (cfgEnables),
  .statusData (statusData),
  .irqOut     (irqOut)
);

// File: tb/uart_irq_prio_tb.sv
module uart_irq_prio_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] evtIn = '0;
  logic       statusRd = 1'b0;
  logic       cfgWr = 1'b0;
  logic [4:0] cfgEnables = '0;
  logic       cfgFifoOn = 1'b0;
  wire  [7:0] statusData;
  wire        irqOut;

  uart_irq_prio u_dut (
    .clk        (clk),
    .rst        (rst),
    .evtIn      (evtIn),
    .statusRd   (statusRd),
    .cfgWr      (cfgWr),
    .cfgEnables (cfgEnables),
    .cfgFifoOn  (cfgFifoOn),
    .statusData (statusData),
    .irqOut     (irqOut)
  );

  always #5 clk = ~clk;

  int    nTests = 0;
  int    nFail  = 0;
  bit    live   = 0;
  bit    done   = 0;
  string phase  = "R1";

  // Expected low nibbles, rank order (R2).
  logic [3:0] expCode [5] = '{4'h6, 4'h4, 4'hC, 4'h2, 4'h0};

  // Behavioural reference model.
  bit mPend [5];
  bit mEn   [5];
  bit mFifo;

  function automatic logic [7:0] refStatus();
    for (int i = 0; i < 5; i++)
      if (mPend[i]) return {mFifo, mFifo, 2'b00, expCode[i]};
    return {mFifo, mFifo, 6'b000001};
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int win;
    if (rst) begin
      for (int i = 0; i < 5; i++) begin mPend[i] = 0; mEn[i] = 0; end
      mFifo = 0;
    end else begin
      win = -1;
      for (int i = 0; i < 5; i++) if (mPend[i] && win < 0) win = i;
      if (statusRd && win >= 0) mPend[win] = 0;
      if (cfgWr) begin
        for (int i = 0; i < 5; i++) mEn[i] = cfgEnables[i];
        mFifo = cfgFifoOn;
      end
      for (int i = 0; i < 5; i++) mPend[i] = mEn[i] && (mPend[i] || evtIn[i]);
    end
    live = 1;
  end

  always @(negedge clk) begin
    if (live && !done) begin
      check(phase, "model status", statusData, refStatus());
      check(phase, "model irq", {7'b0, irqOut}, {7'b0, ~refStatus()[0]});
    end
  end

  task automatic cyc(logic [4:0] evt, logic rd, logic wr, logic [4:0] en, logic fifo);
    evtIn = evt; statusRd = rd; cfgWr = wr;
    if (wr) begin cfgEnables = en; cfgFifoOn = fifo; end
    @(posedge clk);
    #1 evtIn = '0; statusRd = 0; cfgWr = 0;
    @(negedge clk);
  endtask

  task automatic rd();
    cyc(5'b0, 1'b1, 1'b0, 5'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    phase = "R1";
    check("R1", "reset status", statusData, 8'h01);
    check("R1", "reset irq", {7'b0, irqOut}, 8'h00);

    cyc(5'b0, 0, 1, 5'b11111, 0);
    for (int i = 0; i < 5; i++) begin
      phase = "R2";
      cyc(5'(1 << i), 0, 0, 5'b0, 0);
      check("R2", "single source code", statusData, {4'h0, expCode[i]});
      check("R5", "irq high on pending", {7'b0, irqOut}, 8'h01);
      rd();
      check("R7", "read empties single", statusData, 8'h01);
      check("R5", "irq low on idle", {7'b0, irqOut}, 8'h00);
    end

    phase = "R6";
    cyc(5'b0, 0, 1, 5'b11111, 1);
    check("R6", "fifo bits idle", statusData, 8'hC1);
    cyc(5'b00001, 0, 0, 5'b0, 0);
    check("R6", "fifo bits with code", statusData, 8'hC6);
    rd();
    cyc(5'b0, 0, 1, 5'b11111, 0);
    check("R6", "fifo bits cleared", statusData, 8'h01);

    phase = "R3";
    cyc(5'b11111, 0, 0, 5'b0, 0);
    check("R3", "all pending top", statusData, 8'h06);
    rd(); check("R4", "ready before timeout", statusData, 8'h04);
    rd(); check("R7", "timeout next", statusData, 8'h0C);
    rd(); check("R3", "tx empty next", statusData, 8'h02);
    rd(); check("R3", "modem last", statusData, 8'h00);
    rd(); check("R7", "drained", statusData, 8'h01);

    phase = "R4";
    cyc(5'b00110, 0, 0, 5'b0, 0);
    check("R4", "ready over timeout", statusData, 8'h04);
    rd(); check("R4", "timeout remains", statusData, 8'h0C);
    rd();

    phase = "R8";
    cyc(5'b00010, 0, 0, 5'b0, 0);
    cyc(5'b00010, 1, 0, 5'b0, 0);
    check("R8", "event re-sets cleared flag", statusData, 8'h04);
    rd(); check("R8", "then clears", statusData, 8'h01);

    phase = "R11";
    cyc(5'b01000, 0, 0, 5'b0, 0);
    repeat (4) cyc(5'b0, 0, 0, 5'b0, 0);
    check("R11", "flag holds", statusData, 8'h02);
    rd();

    phase = "R9";
    cyc(5'b0, 0, 1, 5'b11101, 0);
    cyc(5'b00010, 0, 0, 5'b0, 0);
    check("R9", "disabled source ignored", statusData, 8'h01);
    check("R9", "no irq from disabled", {7'b0, irqOut}, 8'h00);

    phase = "R10";
    cyc(5'b0, 0, 1, 5'b11111, 0);
    cyc(5'b11000, 0, 0, 5'b0, 0);
    check("R10", "tx shown first", statusData, 8'h02);
    cyc(5'b0, 0, 1, 5'b10111, 0);
    check("R10", "disable drops tx", statusData, 8'h00);
    cyc(5'b0, 0, 1, 5'b11111, 0);
    check("R10", "re-enable does not revive", statusData, 8'h00);
    rd();
    check("R7", "final idle", statusData, 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule